// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is a unified address translation buffer that both instruction fetches and data accesses share. It holds a parameterised number of entries, 64 by default. Each entry carries its own page size, from 1 KiB up to 16 MiB in steps of four. Software owns the contents entirely. Through a plain register-style port it writes and reads either word of an entry, and it can search for an address. It can also drop the valid flag of one entry, chosen by address, or of every entry at once. There is no hardware refill.

A lookup enters on a valid/ready stream. The block compares the effective address against every valid entry in the same cycle. Each compare is masked by that entry's own page size, and the lowest matching index wins. The result leaves on a second valid/ready stream one cycle after the lookup is accepted. It carries hit or miss, the entry index, the physical address, the permission, zone and attribute bits, and execute and write fault flags.

The back-pressure rules are as follows. `lk_ready` is high whenever the result register is empty or is being drained in the same cycle. A result is held unchanged while `rs_valid` is high and `rs_ready` is low. The software controls and status pins are plain and have no handshake.

Top module: `vpt_tlb`

## Requirements
- R1: Software write (`sw_wr`) stores `sw_wdata` into entry `sw_idx`: the tag word when `sw_sel`=0, the data word when `sw_sel`=1. The write is visible from the next cycle. A read (`sw_rd`) returns the selected word of the entry on `sw_rdata` one cycle later, with the contents as they stood before any write issued in the same cycle. `sw_rdata` holds its value between reads.
- R2: The tag word holds the effective page number in bits 31:10, the size code in bits 9:7 and the valid flag in bit 6. Bits 5:0 are stored and read back but ignored. An entry whose bit 6 is clear never matches.
- R3: For size code n (0..7, meaning 1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M), the address compare ignores the low 10+2n bits.
- R4: On a hit, `rs_paddr` takes the data word's bits above bit 10+2n-1 and the effective address's bits below that point unchanged.
- R5: When several valid entries match, the lowest index is reported and used.
- R6: On a hit, `rs_exec_ok` is data bit 9 and `rs_write_ok` is data bit 8. `rs_zone` is data bits 7:4. `rs_attr` is data bits 3:0 in the order write-through (3), cache-inhibit (2), coherent (1), guarded (0).
- R7: `lk_kind` encodes 0 as load, 1 as store and 2 as fetch; 3 is treated as a load. A fetch hit with exec bit clear sets `rs_xfault`. A store hit with write bit clear sets `rs_wfault`. Neither fault is raised on a miss.
- R8: On a miss, `rs_miss`=1 and `rs_hit`=0, and index, address, permission, zone, attribute and fault outputs are all zero.
- R9: `lk_ready` = !`rs_valid` || `rs_ready`. An accepted lookup yields `rs_valid` on the next cycle, evaluated against the table as it stood in the accept cycle. A result is held stable until `rs_ready` is high.
- R10: A search (`sw_find`) sets `find_hit` and `find_idx` on the next cycle, using the same size-masked, lowest-index compare (index 0 on a miss). The search outputs hold between searches.
- R11: `inv_one` clears the valid flag of the lowest-index valid entry that matches `inv_addr`. `inv_all` clears every valid flag and overrides any write or `inv_one` in the same cycle. A write issued together with `inv_one` is applied after the invalidate.
- R12: After reset, every entry reads as zero and `rs_valid`, `sw_rdata`, `find_hit` and `find_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_addr | input | 32 | Effective address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_hit | output | 1 | Translation found |
| rs_miss | output | 1 | No valid entry matched |
| rs_idx | output | IW | Index of the matching entry |
| rs_paddr | output | 32 | Translated physical address |
| rs_exec_ok | output | 1 | Execute permitted |
| rs_write_ok | output | 1 | Write permitted |
| rs_zone | output | 4 | Zone select field |
| rs_attr | output | 4 | Write-through, inhibit, coherent, guarded |
| rs_xfault | output | 1 | Fetch hit on non-executable page |
| rs_wfault | output | 1 | Store hit on read-only page |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_idx | input | IW | Entry index for read or write |
| sw_sel | input | 1 | 0 tag word, 1 data word |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data |
| sw_find | input | 1 | Search strobe |
| sw_find_addr | input | 32 | Address to search for |
| find_hit | output | 1 | Search found a valid match |
| find_idx | output | IW | Index found by the search |
| inv_one | input | 1 | Invalidate the entry matching inv_addr |
| inv_addr | input | 32 | Address for single invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default of 64 entries, so the index is 6 bits wide. This reaches the last entry, index 63, and lets overlapping pages of different sizes sit at distant indices, so lowest-index priority is tested across the full range. Random writes cover every index with all eight size codes. Lookup addresses are drawn around a few base pages, so both hits and misses of every size occur often, under random result back-pressure and alongside searches and invalidates in the same cycles.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 10;

  // access kind carried with each lookup
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // bits kept by the compare for a given size code: low 10+2n bits cleared
  function automatic logic [WORD_W-1:0] keep_mask(input logic [2:0] sz);
    return {WORD_W{1'b1}} << (PAGE_LSB + 2 * int'(sz));
  endfunction

endpackage

// File: rtl/vpt_match.sv
module vpt_match import vpt_pkg::*; #(
  parameter int N = 64
) (
  input  logic [N-1:0][WORD_W-1:0] tags,
  input  logic [WORD_W-1:0]        addr,
  output logic [N-1:0]             hits
);

  // one size-masked comparator per entry
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [WORD_W-1:0] keep;
    assign keep    = keep_mask(tags[g][9:7]);
    assign hits[g] = tags[g][6] && (((addr ^ tags[g]) & keep) == '0);
  end

endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  // scan downward so the lowest requesting index is the last assigned
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/vpt_table.sv
module vpt_table import vpt_pkg::*; #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic                     wr_sel,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     inv_one,
  input  logic [IW-1:0]            inv_idx,
  input  logic                     inv_all,
  output logic [N-1:0][WORD_W-1:0] tags,
  output logic [N-1:0][WORD_W-1:0] datas
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags  <= '0;
      datas <= '0;
    end else if (inv_all) begin
      for (int i = 0; i < N; i++) tags[i][6] <= 1'b0;
    end else begin
      if (inv_one) tags[inv_idx][6] <= 1'b0;
      if (wr_en) begin
        if (wr_sel) datas[wr_idx] <= wr_data;
        else        tags[wr_idx]  <= wr_data;
      end
    end
  end

  logic [N-1:0] valid_vec;
  for (genvar g = 0; g < N; g++) begin : g_vld
    assign valid_vec[g] = tags[g][6];
  end

  // R11
  inv_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));

  // R11
  inv_one_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && !inv_all && !(wr_en && !wr_sel && wr_idx == inv_idx))
      |=> !valid_vec[$past(inv_idx)]);

  // R1
  tag_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !inv_all) |=> (tags[$past(wr_idx)] == $past(wr_data)));

  // R1
  data_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !inv_all) |=> (datas[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb import vpt_pkg::*; #(
  parameter  int ENTRIES = 64,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [31:0]       lk_addr,
  input  logic [1:0]        lk_kind,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic              rs_miss,
  output logic [IW-1:0]     rs_idx,
  output logic [31:0]       rs_paddr,
  output logic              rs_exec_ok,
  output logic              rs_write_ok,
  output logic [3:0]        rs_zone,
  output logic [3:0]        rs_attr,
  output logic              rs_xfault,
  output logic              rs_wfault,
  input  logic              sw_wr,
  input  logic              sw_rd,
  input  logic [IW-1:0]     sw_idx,
  input  logic              sw_sel,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              sw_find,
  input  logic [31:0]       sw_find_addr,
  output logic              find_hit,
  output logic [IW-1:0]     find_idx,
  input  logic              inv_one,
  input  logic [31:0]       inv_addr,
  input  logic              inv_all
);

  logic [ENTRIES-1:0][WORD_W-1:0] tags;
  logic [ENTRIES-1:0][WORD_W-1:0] datas;

  logic [ENTRIES-1:0] lk_hits, fd_hits, iv_hits;
  logic               lk_any, fd_any, iv_any;
  logic [IW-1:0]      lk_sel, fd_sel, iv_sel;

  // ---------------- storage ----------------
  vpt_table #(.N(ENTRIES), .IW(IW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sw_wr),
    .wr_idx  (sw_idx),
    .wr_sel  (sw_sel),
    .wr_data (sw_wdata),
    .inv_one (inv_one && iv_any),
    .inv_idx (iv_sel),
    .inv_all (inv_all),
    .tags    (tags),
    .datas   (datas)
  );

  // ---------------- three parallel compare paths ----------------
  vpt_match #(.N(ENTRIES)) u_lk_match (.tags(tags), .addr(lk_addr),      .hits(lk_hits));
  vpt_match #(.N(ENTRIES)) u_fd_match (.tags(tags), .addr(sw_find_addr), .hits(fd_hits));
  vpt_match #(.N(ENTRIES)) u_iv_match (.tags(tags), .addr(inv_addr),     .hits(iv_hits));

  vpt_prio #(.N(ENTRIES), .IW(IW)) u_lk_prio (.req(lk_hits), .any(lk_any), .idx(lk_sel));
  vpt_prio #(.N(ENTRIES), .IW(IW)) u_fd_prio (.req(fd_hits), .any(fd_any), .idx(fd_sel));
  vpt_prio #(.N(ENTRIES), .IW(IW)) u_iv_prio (.req(iv_hits), .any(iv_any), .idx(iv_sel));

  // ---------------- translation of the winning entry ----------------
  logic [WORD_W-1:0] win_data, win_keep, paddr_c;
  always_comb begin
    win_data = datas[lk_sel];
    win_keep = keep_mask(tags[lk_sel][9:7]);
    paddr_c  = (win_data & win_keep) | (lk_addr & ~win_keep);
  end

  logic take;
  assign lk_ready = !rs_valid || rs_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_hit      <= 1'b0;
      rs_miss     <= 1'b0;
      rs_idx      <= '0;
      rs_paddr    <= '0;
      rs_exec_ok  <= 1'b0;
      rs_write_ok <= 1'b0;
      rs_zone     <= '0;
      rs_attr     <= '0;
      rs_xfault   <= 1'b0;
      rs_wfault   <= 1'b0;
    end else if (take) begin
      rs_valid    <= 1'b1;
      rs_hit      <= lk_any;
      rs_miss     <= !lk_any;
      rs_idx      <= lk_any ? lk_sel : '0;
      rs_paddr    <= lk_any ? paddr_c : '0;
      rs_exec_ok  <= lk_any && win_data[9];
      rs_write_ok <= lk_any && win_data[8];
      rs_zone     <= lk_any ? win_data[7:4] : 4'h0;
      rs_attr     <= lk_any ? win_data[3:0] : 4'h0;
      rs_xfault   <= lk_any && (lk_kind == ACC_FETCH) && !win_data[9];
      rs_wfault   <= lk_any && (lk_kind == ACC_STORE) && !win_data[8];
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  // ---------------- software read and search ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_rdata <= '0;
      find_hit <= 1'b0;
      find_idx <= '0;
    end else begin
      if (sw_rd) sw_rdata <= sw_sel ? datas[sw_idx] : tags[sw_idx];
      if (sw_find) begin
        find_hit <= fd_any;
        find_idx <= fd_any ? fd_sel : '0;
      end
    end
  end

  // R8
  miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_miss) |-> (rs_paddr == '0 && rs_idx == '0 && !rs_exec_ok &&
      !rs_write_ok && rs_zone == '0 && rs_attr == '0 && !rs_xfault && !rs_wfault));

  // R9
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_hit != rs_miss));

  // R9
  result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_paddr) && $stable(rs_idx) &&
      $stable(rs_hit) && $stable(rs_attr)));

  // R7
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && (rs_xfault || rs_wfault)) |-> rs_hit);

  // R7
  xfault_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_xfault) |-> !rs_exec_ok);

  // R7
  wfault_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_wfault) |-> !rs_write_ok);

  // R10
  find_miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !find_hit |-> (find_idx == '0));

endmodule

// File: tb/test_vpt_tlb.sv
module test_vpt_tlb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 64;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, rs_ready = 1'b1;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_kind = '0;
  logic        sw_wr = 1'b0, sw_rd = 1'b0, sw_sel = 1'b0, sw_find = 1'b0;
  logic [5:0]  sw_idx = '0;
  logic [31:0] sw_wdata = '0, sw_find_addr = '0, inv_addr = '0;
  logic        inv_one = 1'b0, inv_all = 1'b0;

  logic        lk_ready, rs_valid, rs_hit, rs_miss, rs_exec_ok, rs_write_ok;
  logic        rs_xfault, rs_wfault, find_hit;
  logic [5:0]  rs_idx, find_idx;
  logic [31:0] rs_paddr, sw_rdata;
  logic [3:0]  rs_zone, rs_attr;

  vpt_tlb #(.ENTRIES(N)) i_vpt_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_kind(lk_kind),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_miss(rs_miss),
    .rs_idx(rs_idx), .rs_paddr(rs_paddr), .rs_exec_ok(rs_exec_ok),
    .rs_write_ok(rs_write_ok), .rs_zone(rs_zone), .rs_attr(rs_attr),
    .rs_xfault(rs_xfault), .rs_wfault(rs_wfault),
    .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_idx(sw_idx), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .sw_find(sw_find), .sw_find_addr(sw_find_addr), .find_hit(find_hit),
    .find_idx(find_idx), .inv_one(inv_one), .inv_addr(inv_addr), .inv_all(inv_all)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  string ctx   = "reset";

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s (%s): actual %h expected %h", req, what, ctx, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_tag [N];
  logic [31:0] m_data[N];
  logic        e_valid, e_hit, e_xf, e_wf, e_found;
  logic [31:0] e_paddr, e_rdata, e_dword;
  int          e_idx, e_fidx;

  function automatic void mlook(input logic [31:0] a, output logic h, output int ix);
    int sh;
    h = 1'b0; ix = 0;
    for (int i = 0; i < N; i++) begin
      sh = 10 + 2 * int'(m_tag[i][9:7]);
      if (!h && m_tag[i][6] && ((a >> sh) == (m_tag[i] >> sh))) begin
        h = 1'b1; ix = i;
      end
    end
  endfunction

  always @(posedge clk) begin
    logic h; int ix, sh;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; end
      e_valid = 0; e_hit = 0; e_xf = 0; e_wf = 0; e_found = 0;
      e_paddr = '0; e_rdata = '0; e_dword = '0; e_idx = 0; e_fidx = 0;
    end else begin
      if (lk_valid && (!e_valid || rs_ready)) begin
        mlook(lk_addr, h, ix);
        e_valid = 1; e_hit = h;
        if (h) begin
          sh      = 10 + 2 * int'(m_tag[ix][9:7]);
          e_idx   = ix;
          e_dword = m_data[ix];
          e_paddr = ((m_data[ix] >> sh) << sh) | (lk_addr & ((32'h1 << sh) - 1));
          e_xf    = (lk_kind == 2'd2) && !m_data[ix][9];
          e_wf    = (lk_kind == 2'd1) && !m_data[ix][8];
        end else begin
          e_idx = 0; e_dword = '0; e_paddr = '0; e_xf = 0; e_wf = 0;
        end
      end else if (rs_ready) begin
        e_valid = 0;
      end
      if (sw_rd) e_rdata = sw_sel ? m_data[sw_idx] : m_tag[sw_idx];
      if (sw_find) begin
        mlook(sw_find_addr, h, ix);
        e_found = h; e_fidx = h ? ix : 0;
      end
      if (inv_all) begin
        for (int i = 0; i < N; i++) m_tag[i][6] = 1'b0;
      end else begin
        if (inv_one) begin
          mlook(inv_addr, h, ix);
          if (h) m_tag[ix][6] = 1'b0;
        end
        if (sw_wr) begin
          if (sw_sel) m_data[sw_idx] = sw_wdata;
          else        m_tag[sw_idx]  = sw_wdata;
        end
      end
    end
  end

  // compare every clock, a little after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R9", "lk_ready", 32'(lk_ready), 32'(!e_valid || rs_ready));
      chk("R9", "rs_valid", 32'(rs_valid), 32'(e_valid));
      if (e_valid) begin
        chk("R2 R3", "rs_hit", 32'(rs_hit), 32'(e_hit));
        chk("R8", "rs_miss", 32'(rs_miss), 32'(!e_hit));
        chk("R5", "rs_idx", 32'(rs_idx), 32'(e_idx));
        chk("R4", "rs_paddr", rs_paddr, e_paddr);
        chk("R6", "perm/zone/attr",
            {22'd0, rs_exec_ok, rs_write_ok, rs_zone, rs_attr}, {22'd0, e_dword[9:0]});
        chk("R7", "faults", {30'd0, rs_xfault, rs_wfault}, {30'd0, e_xf, e_wf});
      end
      chk("R1", "sw_rdata", sw_rdata, e_rdata);
      chk("R10", "find", {25'd0, find_hit, find_idx}, {25'd0, e_found, 6'(e_fidx)});
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic tick();
    @(negedge clk);
    lk_valid = 0; sw_wr = 0; sw_rd = 0; sw_find = 0; inv_one = 0; inv_all = 0;
  endtask

  task automatic put(input int ix, input logic [31:0] t, input logic [31:0] d);
    sw_wr = 1; sw_idx = 6'(ix); sw_sel = 0; sw_wdata = t; tick();
    sw_wr = 1; sw_idx = 6'(ix); sw_sel = 1; sw_wdata = d; tick();
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] k);
    lk_valid = 1; lk_addr = a; lk_kind = k; tick();
  endtask

  task automatic rd(input int ix, input logic s);
    sw_rd = 1; sw_idx = 6'(ix); sw_sel = s; tick();
  endtask

  task automatic find(input logic [31:0] a);
    sw_find = 1; sw_find_addr = a; tick();
  endtask

  function automatic logic [31:0] mk_tag(input logic [31:0] base, input int sz, input bit v);
    return (base & 32'hFFFF_FC00) | (32'(sz) << 7) | (v ? 32'h40 : 32'h0);
  endfunction

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      n_checks++; n_fails++;
      $display("FAIL R9 watchdog: actual cycles %0d expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  logic [31:0] bases [6] = '{32'h1000_0400, 32'h2000_0000, 32'h3000_0000,
                             32'h4000_0000, 32'h6000_0000, 32'h7000_0000};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ctx = "after reset";
    chk("R12", "rs_valid at reset", 32'(rs_valid), 32'h0);
    chk("R12", "lk_ready at reset", 32'(lk_ready), 32'h1);
    chk("R12", "sw_rdata at reset", sw_rdata, 32'h0);
    chk("R12", "find_hit at reset", 32'(find_hit), 32'h0);
    rd(17, 0); rd(17, 1);

    ctx = "program entries";
    put(0,  mk_tag(32'h1000_0400, 0, 1), 32'h8000_0000 | 32'h300 | 32'h3A);
    put(1,  mk_tag(32'h2000_0000, 1, 1), 32'h8100_0000 | 32'h100 | 32'h51);
    put(2,  mk_tag(32'h3000_0000, 3, 1) | 32'h3F, 32'h8200_0000 | 32'h200 | 32'h04);
    put(3,  mk_tag(32'h4000_0000, 7, 1), 32'h9000_0000 | 32'h300 | 32'hF2);
    put(5,  mk_tag(32'h4000_4000, 2, 1), 32'hA000_0000 | 32'h100 | 32'h08);
    put(7,  mk_tag(32'h5000_0000, 4, 0), 32'hB000_0300);
    put(10, mk_tag(32'h2000_0000, 0, 1), 32'hC000_0300);
    put(63, mk_tag(32'h6000_0000, 5, 1), 32'hD000_0000 | 32'h300 | 32'h91);
    ctx = "R1 readback with ignored low tag bits"; rd(2, 0); rd(2, 1); rd(63, 0);

    ctx = "R3 size boundaries and R4 splice";
    look(32'h1000_07FC, 2'd0); look(32'h1000_0800, 2'd0);
    look(32'h2000_0FFF, 2'd0); look(32'h2000_1000, 2'd0);
    look(32'h3000_ABCD, 2'd2); look(32'h3001_0000, 2'd2);
    look(32'h6009_1234, 2'd1); look(32'h4012_3456, 2'd0);
    ctx = "R5 overlap lowest wins"; look(32'h2000_0123, 2'd0); look(32'h4000_4444, 2'd0);
    ctx = "R2 invalid entry";       look(32'h5000_0010, 2'd0);
    ctx = "R7 faults";
    look(32'h2000_0040, 2'd2); look(32'h3000_0040, 2'd1);
    look(32'h2000_0040, 2'd1); look(32'h3000_0040, 2'd3);
    look(32'h7777_0000, 2'd2);

    ctx = "R9 back-pressure";
    rs_ready = 0; look(32'h1000_0400, 2'd0);
    lk_valid = 1; lk_addr = 32'h6000_0000; @(negedge clk);
    @(negedge clk); @(negedge clk);
    rs_ready = 1; @(negedge clk); lk_valid = 0; tick();

    ctx = "R10 search";
    find(32'h4000_4000); find(32'h7000_0000); find(32'h600F_FFFF);

    ctx = "R11 invalidate one";
    inv_one = 1; inv_addr = 32'h40FF_0000; tick();
    look(32'h4000_4000, 2'd0); rd(3, 0); find(32'h4000_4000);
    ctx = "R11 write with invalidate";
    inv_one = 1; inv_addr = 32'h2000_0000; sw_wr = 1; sw_idx = 1; sw_sel = 0;
    sw_wdata = mk_tag(32'h2000_0000, 1, 1); tick();
    look(32'h2000_0010, 2'd0); rd(1, 0);
    ctx = "R11 invalidate all overrides write";
    inv_all = 1; sw_wr = 1; sw_idx = 9; sw_sel = 0; sw_wdata = mk_tag(32'h7000_0000, 0, 1); tick();
    rd(9, 0); look(32'h6000_0000, 2'd0); look(32'h1000_0400, 2'd0); find(32'h1000_0400);

    ctx = "random traffic";
    for (int c = 0; c < 3000; c++) begin
      lk_valid = ($urandom % 2) == 0;
      lk_addr  = bases[$urandom % 6] + ($urandom % 32'h0004_0000);
      lk_kind  = 2'($urandom % 4);
      rs_ready = ($urandom % 4) != 0;
      sw_rd    = ($urandom % 6) == 0;
      sw_find  = ($urandom % 6) == 0;
      sw_find_addr = bases[$urandom % 6] + ($urandom % 32'h0004_0000);
      sw_idx   = 6'($urandom % N);
      sw_sel   = 1'($urandom % 2);
      sw_wr    = ($urandom % 5) == 0;
      sw_wdata = sw_sel ? $urandom
                        : mk_tag(bases[$urandom % 6] + ($urandom % 32'h0004_0000),
                                 int'($urandom % 8), ($urandom % 8) != 0);
      inv_one  = ($urandom % 24) == 0;
      inv_addr = bases[$urandom % 6] + ($urandom % 32'h0004_0000);
      inv_all  = ($urandom % 400) == 0;
      @(negedge clk);
    end
    tick(); rs_ready = 1; tick(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule